// File: doc/BRIEF.md
# Error-detection packet insert/delete controller

This block sits in a 10-bit parallel video path running on the pixel clock. A separate timing decoder tells it where each field begins, which words belong to the active picture and to the full field, and where the error-detection packet slot of the field starts. For every packet slot the block chooses one of three actions:

- **Insert.** It writes a freshly built packet into the slot.
- **Delete.** It blanks the incoming packet.
- **Pass.** It lets the incoming words through untouched.

A freshly built packet carries two 16-bit checkwords, one for the active picture and one for the full field. Both are taken from the field that has just finished. It also carries two error-flag words, which come from host-programmed registers and not from any received packet.

The two checkwords are accumulated word by word over the input video. The accumulators restart at the first word of each field. The previous accumulated values are frozen at that moment, so the packet built later in the field covers one complete field. The output is registered, so every output word trails the input by exactly one clock.

Top module: `edh_ctrl`

## Requirements
- R1: While reset is held, `vid_out` is 000h.
- R2: Outside a packet slot, `vid_out` equals `vid_in` one clock later.
- R3: The action for a slot is chosen on the clock where `pkt_slot` starts it. When the action is insert, the slot's first five output words are 000h, 3FFh, 3FFh, 1F4h (identifier) and 110h (user word count 16).
- R4: In an inserted packet, the 16 user words follow the header, one per output word.
  - Each user word carries a 6-bit value in bits 7:2. Bits 1:0 are zero. Bit 8 is the even parity of bits 7:0, and bit 9 is its inverse.
  - The values, in order, are:
    - user words 0 to 2: the active-picture checkword as bits 5:0, then bits 11:6, then bits 15:12;
    - user words 3 to 5: the full-field checkword, split the same way;
    - user word 6: `ap_err`;
    - user word 7: `ff_err`;
    - user words 8 to 15: zero.
- R5: The 22nd and last word of an inserted packet is the checksum. Its bits 8:0 are the 9-bit sum of bits 8:0 of words 4 to 21 of the slot, that is, the identifier, the word count and the 16 user words. Its bit 9 is the inverse of its bit 8.
- R6: With `cfg_insert` low, `cfg_cascade` low and `cfg_keep_rx` low, the 22 words of the slot become 200h and 040h alternately, starting with 200h.
- R7: With `cfg_insert` low and `cfg_keep_rx` high, the 22 slot words pass through unchanged.
- R8: With `cfg_insert` low and `cfg_cascade` high, the slot passes through unchanged whatever the value of `cfg_keep_rx`.
- R9: `cfg_insert` high selects insert regardless of `cfg_keep_rx` and `cfg_cascade`.
- R10: Each checkword is a CRC with polynomial x^16+x^12+x^5+1.
  - It is computed over all ten bits of each word, MSB first, starting from zero.
  - The active-picture CRC covers the words with `ap_active` high. The full-field CRC covers the words with `ff_active` high.
  - Both restart at the word marked by `field_start`, and that word counts toward the new field.
  - A packet uses the values frozen at the latest `field_start`. A field with no active-picture words therefore yields an active-picture checkword of 0000h.
- R11: A `pkt_slot` pulse that arrives while a slot is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_in | input | 10 | Incoming video word |
| field_start | input | 1 | First word of a field |
| ap_active | input | 1 | Word belongs to the active-picture CRC range |
| ff_active | input | 1 | Word belongs to the full-field CRC range |
| pkt_slot | input | 1 | First word of the error-detection packet slot |
| cfg_insert | input | 1 | Build and insert a new packet |
| cfg_keep_rx | input | 1 | High: pass received packets; low: delete them |
| cfg_cascade | input | 1 | High: the delete option is disabled |
| ap_err | input | 5 | Error flags for the active-picture flag word |
| ff_err | input | 5 | Error flags for the full-field flag word |
| vid_out | output | 10 | Outgoing video word |

## Verification
The assertions check, on every cycle, four properties of the data path:
- words outside a slot leave one clock later unchanged;
- an insert slot opens with 000h;
- a delete slot opens with 200h;
- a pass slot under `cfg_keep_rx` or `cfg_cascade` opens with the incoming word.

The user-word contents, the CRC values across field boundaries, the checksum, the alternation of blanking words and the handling of a second slot pulse all depend on whole packets and whole fields. Only the bench's reference model checks them, comparing every output word across fields with different data, flags and control settings.

// File: rtl/edh_ctrl.sv
module edh_ctrl #(
  parameter int          UDW_N = 16,
  parameter logic [15:0] POLY  = 16'h1021,
  parameter logic [7:0]  DID   = 8'hF4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] vid_in,
  input  logic       field_start,
  input  logic       ap_active,
  input  logic       ff_active,
  input  logic       pkt_slot,
  input  logic       cfg_insert,
  input  logic       cfg_keep_rx,
  input  logic       cfg_cascade,
  input  logic [4:0] ap_err,
  input  logic [4:0] ff_err,
  output logic [9:0] vid_out
);
  localparam int HDR_N = 5;
  localparam int PKT_N = HDR_N + UDW_N + 1;
  localparam int LAST  = PKT_N - 1;
  localparam int CW    = $clog2(PKT_N);

  typedef enum logic [1:0] {M_PASS, M_DEL, M_INS} mode_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [9:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 9; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [9:0] par8(input logic [7:0] v);
    return {~(^v), ^v, v};
  endfunction

  logic          busy;
  logic [CW-1:0] cnt;
  mode_t         mode_r;
  logic [15:0]   ap_acc, ff_acc, ap_hold, ff_hold;
  logic [8:0]    sum;

  wire           start = pkt_slot & ~busy;
  wire           in_pkt = start | busy;
  wire  [CW-1:0] idx = start ? '0 : cnt;
  wire  [CW-1:0] k = idx - CW'(HDR_N);

  mode_t pick, mode;
  assign pick = cfg_insert ? M_INS : (!cfg_cascade && !cfg_keep_rx) ? M_DEL : M_PASS;
  assign mode = start ? pick : mode_r;

  logic [5:0] uval;
  always_comb begin
    case (k)
      CW'(0):  uval = ap_hold[5:0];
      CW'(1):  uval = ap_hold[11:6];
      CW'(2):  uval = {2'b00, ap_hold[15:12]};
      CW'(3):  uval = ff_hold[5:0];
      CW'(4):  uval = ff_hold[11:6];
      CW'(5):  uval = {2'b00, ff_hold[15:12]};
      CW'(6):  uval = {1'b0, ap_err};
      CW'(7):  uval = {1'b0, ff_err};
      default: uval = 6'd0;
    endcase
  end

  logic [9:0] ins_word;
  always_comb begin
    if (idx == '0)                  ins_word = 10'h000;
    else if (idx < CW'(3))          ins_word = 10'h3FF;
    else if (idx == CW'(3))         ins_word = par8(DID);
    else if (idx == CW'(4))         ins_word = par8(8'(UDW_N));
    else if (idx == CW'(LAST))      ins_word = {~sum[8], sum};
    else                            ins_word = par8({uval, 2'b00});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      mode_r <= M_PASS;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= CW'(1);
      mode_r <= pick;
    end else if (busy) begin
      if (cnt == CW'(LAST)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sum <= '0;
    else if (start)
      sum <= '0;
    else if (busy && mode_r == M_INS && cnt >= CW'(3) && cnt < CW'(LAST))
      sum <= sum + ins_word[8:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_acc <= '0; ff_acc <= '0; ap_hold <= '0; ff_hold <= '0;
    end else if (field_start) begin
      ap_hold <= ap_acc;
      ff_hold <= ff_acc;
      ap_acc  <= ap_active ? crc_step(16'h0000, vid_in) : 16'h0000;
      ff_acc  <= ff_active ? crc_step(16'h0000, vid_in) : 16'h0000;
    end else begin
      if (ap_active) ap_acc <= crc_step(ap_acc, vid_in);
      if (ff_active) ff_acc <= crc_step(ff_acc, vid_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      vid_out <= 10'h000;
    else if (in_pkt && mode == M_INS)
      vid_out <= ins_word;
    else if (in_pkt && mode == M_DEL)
      vid_out <= idx[0] ? 10'h040 : 10'h200;
    else
      vid_out <= vid_in;
  end
endmodule

// File: rtl/edh_ctrl_chk.sv
module edh_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] vid_in,
  input logic [9:0] vid_out,
  input logic       pkt_slot,
  input logic       busy,
  input logic       cfg_insert,
  input logic       cfg_keep_rx,
  input logic       cfg_cascade
);
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_slot && !busy) |=> vid_out == $past(vid_in));

  p_ins_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_slot && !busy && cfg_insert) |=> vid_out == 10'h000);

  p_del_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_slot && !busy && !cfg_insert && !cfg_cascade && !cfg_keep_rx) |=> vid_out == 10'h200);

  p_keep_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_slot && !busy && !cfg_insert && cfg_keep_rx) |=> vid_out == $past(vid_in));

  p_cascade_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_slot && !busy && !cfg_insert && cfg_cascade) |=> vid_out == $past(vid_in));
endmodule

bind edh_ctrl edh_ctrl_chk u_chk (.*);

// File: tb/edh_ctrl_bench.sv
module edh_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] vid_in = '0;
  logic       field_start = 1'b0, ap_active = 1'b0, ff_active = 1'b0, pkt_slot = 1'b0;
  logic       cfg_insert = 1'b0, cfg_keep_rx = 1'b0, cfg_cascade = 1'b0;
  logic [4:0] ap_err = '0, ff_err = '0;
  logic [9:0] vid_out;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edh_ctrl u_edh_ctrl (.*);

  localparam int FLEN = 80, PKT_AT = 52, NW = 22;

  int    exp_out = 0;
  string exp_tag = "R1";
  int    ap_acc, ff_acc, ap_hold, ff_hold;
  int    pos = -1, mmode = 0;
  int    pkt[NW];
  string udw_tag = "R4", pass_tag = "R7", pkt_tag = "", m_pkt_tag = "", m_udw_tag = "", m_pass_tag = "";

  function automatic int bcrc(int c, int d);
    int r = c;
    for (int i = 9; i >= 0; i--) begin
      int top = ((r >> 15) & 1) ^ ((d >> i) & 1);
      r = (r << 1) & 'hFFFF;
      if (top != 0) r = r ^ 'h1021;
    end
    return r;
  endfunction

  function automatic int anc(int v8);
    int p = $countones(v8[7:0]) & 1;
    return ((1 - p) << 9) | (p << 8) | (v8 & 'hFF);
  endfunction

  task automatic build_pkt();
    int vals[16];
    int s = 0;
    vals[0] = ap_hold & 63; vals[1] = (ap_hold >> 6) & 63; vals[2] = (ap_hold >> 12) & 15;
    vals[3] = ff_hold & 63; vals[4] = (ff_hold >> 6) & 63; vals[5] = (ff_hold >> 12) & 15;
    vals[6] = int'(ap_err); vals[7] = int'(ff_err);
    for (int i = 8; i < 16; i++) vals[i] = 0;
    pkt[0] = 'h000; pkt[1] = 'h3FF; pkt[2] = 'h3FF; pkt[3] = 'h1F4; pkt[4] = 'h110;
    for (int i = 0; i < 16; i++) pkt[5 + i] = anc(vals[i] << 2);
    for (int i = 3; i < 21; i++) s = (s + (pkt[i] & 'h1FF)) & 'h1FF;
    pkt[21] = s | ((((s >> 8) & 1) ^ 1) << 9);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_out = 0; exp_tag = "R1";
      ap_acc = 0; ff_acc = 0; ap_hold = 0; ff_hold = 0; pos = -1;
    end else begin
      if (pkt_slot && pos < 0) begin
        pos = 0;
        mmode = cfg_insert ? 2 : (!cfg_cascade && !cfg_keep_rx) ? 1 : 0;
        m_pkt_tag = pkt_tag; m_udw_tag = udw_tag; m_pass_tag = pass_tag;
        build_pkt();
      end
      if (pos >= 0) begin
        if (mmode == 2) begin
          exp_out = pkt[pos];
          exp_tag = (pos < 5) ? "R3" : (pos < 21) ? m_udw_tag : "R5";
        end else if (mmode == 1) begin
          exp_out = (pos % 2 == 1) ? 'h040 : 'h200;
          exp_tag = "R6";
        end else begin
          exp_out = int'(vid_in);
          exp_tag = m_pass_tag;
        end
        if (m_pkt_tag != "") exp_tag = m_pkt_tag;
        pos++;
        if (pos == NW) pos = -1;
      end else begin
        exp_out = int'(vid_in);
        exp_tag = "R2";
      end
      if (field_start) begin
        ap_hold = ap_acc; ff_hold = ff_acc; ap_acc = 0; ff_acc = 0;
      end
      if (ap_active) ap_acc = bcrc(ap_acc, int'(vid_in));
      if (ff_active) ff_acc = bcrc(ff_acc, int'(vid_in));
    end
  end

  task automatic compare();
    checks++;
    if (int'(vid_out) !== exp_out) begin
      failures++;
      $display("FAIL %s: vid_out=%03h expected=%03h at %0t", exp_tag, vid_out, exp_out[9:0], $time);
    end
  endtask

  int seed = 12345;
  task automatic step(bit fs, bit ap, bit ff, bit ps);
    @(negedge clk);
    compare();
    seed = seed * 1103515245 + 12345;
    vid_in = 10'((seed >>> 7) & 'h3FF);
    field_start = fs; ap_active = ap; ff_active = ff; pkt_slot = ps;
  endtask

  task automatic run_field(bit ins, bit keep, bit casc, bit noap, bit extra, int aperr, int fferr);
    cfg_insert = ins; cfg_keep_rx = keep; cfg_cascade = casc;
    ap_err = 5'(aperr); ff_err = 5'(fferr);
    for (int w = 0; w < FLEN; w++)
      step(w == 0, !noap && w >= 10 && w < 40, 1'b1,
           w == PKT_AT || (extra && w == PKT_AT + 6));
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    run_field(1, 0, 0, 0, 0, 5'h01, 5'h10);
    run_field(1, 0, 0, 0, 0, 5'h1F, 5'h0A);
    run_field(1, 0, 0, 1, 0, 5'h03, 5'h15);
    udw_tag = "R10";
    run_field(1, 0, 0, 0, 0, 5'h11, 5'h02);
    udw_tag = "R4";
    run_field(0, 0, 0, 0, 0, 0, 0);
    pass_tag = "R7";
    run_field(0, 1, 0, 0, 0, 0, 0);
    pass_tag = "R8";
    run_field(0, 0, 1, 0, 0, 0, 0);
    run_field(0, 1, 1, 0, 0, 0, 0);
    pkt_tag = "R9";
    run_field(1, 1, 1, 0, 0, 5'h07, 5'h19);
    pkt_tag = "R11";
    run_field(1, 0, 0, 0, 1, 5'h0C, 5'h13);
    run_field(0, 0, 0, 0, 1, 0, 0);
    pkt_tag = "";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule